// File: doc/BRIEF.md
# Watchdog Timer with Guarded Turn-Off

This block supervises software through a free-running count of watchdog ticks. A tick-enable input marks the cycles in which the count may advance, so a slow reference can drive it without a second clock domain. Software restarts the count with a single-cycle restart strobe. If the count reaches the period chosen by a 3-bit select before any restart arrives, the block emits a one-cycle system reset pulse and starts again from zero.

An 8-bit control register holds the period select, an enable flag and an arming flag for turn-off. Enabling the watchdog is always allowed. Disabling it takes two writes. The first write sets the arming flag. The second write, which clears the enable flag, only takes effect while the arming flag is still set, and hardware drops that flag on its own after a short window. A stray write that clears the enable flag therefore cannot switch the watchdog off.

Top module: `wdog_guard`

## Requirements
- R1: After reset, the read port shows 8'h00 and the reset pulse output is low.
- R2: The read port shows zero in bits 7..5, whatever was written there. It shows the arming flag in bit 4, the enable flag in bit 3 and the period select in bits 2..0.
- R3: A write always loads bits 2..0 into the period select. A write with bit 3 = 1 sets the enable flag, whatever the state of the arming flag.
- R4: A write with bit 4 = 1 sets the arming flag. The flag reads 1 in the four cycles that follow that write edge, and hardware clears it at the fourth edge after the write. A write with bit 4 = 0 does not clear it early.
- R5: A write with bit 3 = 0 clears the enable flag only if the arming flag reads 1 in the cycle of that write. Otherwise the enable flag keeps its value.
- R6: With the enable flag set, the counter starting at zero and no restart, the reset pulse appears right after the edge that samples the 2^(BASE_EXP+select)-th tick-enable cycle.
- R7: The reset pulse lasts exactly one cycle. The count restarts from zero, so the next pulse comes after one more full period of ticks.
- R8: A restart strobe clears the count. When a restart and the terminal tick fall in the same cycle, the restart wins and no pulse is produced.
- R9: While the enable flag is clear, the count is held at zero and no pulse is produced, however many ticks arrive. After the watchdog is enabled again, a full period must pass before a pulse.
- R10: In cycles with tick enable low, the count does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read data |
| wd_kick | input | 1 | Watchdog restart strobe |
| tick_en | input | 1 | Watchdog tick enable |
| sys_rst_pulse | output | 1 | One-cycle system reset request |

## Verification
Two events can fall in the same cycle: a restart strobe and the tick that would reach the terminal count. The bench runs the count to one tick short of the period, then drives a cycle with both the tick enable and the restart high. It checks that no pulse follows and that a full fresh period is then needed. A second overlap is a disabling write on the very last cycle of the arming window. The bench lands that write on the fourth edge, where it must be accepted, and one edge later, where it must be ignored.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   // Register layout; the field positions are part of the software contract
   localparam int WD_SEL_W  = 3;
   localparam int WD_NSEL   = 1 << WD_SEL_W;
   localparam int WD_REG_W  = 8;
   localparam int WD_BIT_ARM = 4;
   localparam int WD_BIT_EN  = 3;

   typedef struct packed {
      logic                arm;
      logic                en;
      logic [WD_SEL_W-1:0] sel;
   } wd_ctrl_t;
endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
   import wdog_pkg::*;
#(
   parameter int ARM_CYCLES = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [WD_REG_W-1:0] wdata,
   output wd_ctrl_t            ctrl
);
   localparam int ARM_W = (ARM_CYCLES > 2) ? $clog2(ARM_CYCLES) : 1;
   localparam logic [ARM_W-1:0] ARM_LAST = ARM_W'(ARM_CYCLES - 1);

   if (ARM_CYCLES < 2) begin : g_bad_arm
      $error("wdog_ctrl_reg: ARM_CYCLES must be at least 2");
   end

   wd_ctrl_t         q;
   logic [ARM_W-1:0] age_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q     <= '0;
         age_q <= '0;
      end else begin
         if (we) begin
            q.sel <= wdata[WD_SEL_W-1:0];
            if (wdata[WD_BIT_EN])
               q.en <= 1'b1;
            else if (q.arm)
               q.en <= 1'b0;
         end
         if (we && wdata[WD_BIT_ARM]) begin
            q.arm <= 1'b1;
            age_q <= '0;
         end else if (q.arm) begin
            if (age_q == ARM_LAST) begin
               q.arm <= 1'b0;
               age_q <= '0;
            end else begin
               age_q <= age_q + 1'b1;
            end
         end
      end
   end

   assign ctrl = q;
endmodule

// File: rtl/wdog_period_dec.sv
module wdog_period_dec
   import wdog_pkg::*;
#(
   parameter int BASE_EXP = 14,
   parameter int CNT_W    = BASE_EXP + WD_NSEL - 1
) (
   input  logic [WD_SEL_W-1:0] sel,
   output logic [CNT_W-1:0]    terminal
);
   if (CNT_W != BASE_EXP + WD_NSEL - 1) begin : g_bad_w
      $error("wdog_period_dec: CNT_W does not match BASE_EXP");
   end

   localparam logic [CNT_W-1:0] ALL_ONES = '1;

   logic [CNT_W-1:0] table_w [WD_NSEL];

   for (genvar i = 0; i < WD_NSEL; i++) begin : g_term
      // period 2^(BASE_EXP+i) ends at count 2^(BASE_EXP+i)-1
      assign table_w[i] = ALL_ONES >> (WD_NSEL - 1 - i);
   end

   assign terminal = table_w[sel];
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
   parameter int CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             kick,
   input  logic             tick,
   input  logic [CNT_W-1:0] terminal,
   output logic             fire
);
   logic [CNT_W-1:0] cnt_q;
   logic             fire_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         fire_q <= 1'b0;
      end else begin
         fire_q <= 1'b0;
         if (!en || kick) begin
            cnt_q <= '0;
         end else if (tick) begin
            if (cnt_q == terminal) begin
               cnt_q  <= '0;
               fire_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign fire = fire_q;
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
   import wdog_pkg::*;
#(
   parameter int BASE_EXP   = 14,
   parameter int ARM_CYCLES = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [WD_REG_W-1:0] cfg_wdata,
   output logic [WD_REG_W-1:0] cfg_rdata,
   input  logic                wd_kick,
   input  logic                tick_en,
   output logic                sys_rst_pulse
);
   localparam int CNT_W = BASE_EXP + WD_NSEL - 1;

   if (BASE_EXP < 1) begin : g_bad_exp
      $error("wdog_guard: BASE_EXP must be positive");
   end

   wd_ctrl_t         ctrl;
   logic [CNT_W-1:0] terminal;

   wdog_ctrl_reg #(.ARM_CYCLES(ARM_CYCLES)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .ctrl  (ctrl)
   );

   wdog_period_dec #(.BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) u_dec (
      .sel      (ctrl.sel),
      .terminal (terminal)
   );

   wdog_count #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ctrl.en),
      .kick     (wd_kick),
      .tick     (tick_en),
      .terminal (terminal),
      .fire     (sys_rst_pulse)
   );

   assign cfg_rdata = {{(WD_REG_W - $bits(wd_ctrl_t)){1'b0}}, ctrl};
endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_we,
   input logic [7:0] cfg_wdata,
   input logic [7:0] cfg_rdata,
   input logic       wd_kick,
   input logic       tick_en,
   input logic       sys_rst_pulse
);
   // R2
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[7:5] == 3'b000);

   // R5
   guarded_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cfg_rdata[3]) |-> $past(cfg_rdata[4]));

   // R3
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(cfg_rdata[2:0]));

   // R7
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_pulse |=> !sys_rst_pulse);

   // R8
   kick_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wd_kick |=> !sys_rst_pulse);

   // R9
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rdata[3] |=> !sys_rst_pulse);

   // R10
   no_tick_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> !sys_rst_pulse);
endmodule

bind wdog_guard wdog_guard_chk u_chk (.*);

// File: tb/sim_wdog_guard.sv
`timescale 1ns/1ps
module sim_wdog_guard;
   localparam int BASE_EXP = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic       wd_kick = 1'b0;
   logic       tick_en = 1'b0;
   logic       sys_rst_pulse;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 0;

   always #2 clk = ~clk;

   wdog_guard #(.BASE_EXP(BASE_EXP), .ARM_CYCLES(4)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .wd_kick(wd_kick), .tick_en(tick_en),
      .sys_rst_pulse(sys_rst_pulse)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000 && !done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] d);
      cfg_we = 1'b1; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // ticks until a pulse is seen; 0 if none within max
   task automatic run_to_pulse(input int max, output int idx);
      idx = 0;
      for (int i = 1; i <= max; i++) begin
         tick_en = 1'b1;
         @(negedge clk);
         if (sys_rst_pulse) begin idx = i; break; end
      end
      tick_en = 1'b0;
   endtask

   task automatic turn_off();
      wr(8'h18); idle(2); wr(8'h00);
   endtask

   task automatic t_reset();
      check(cfg_rdata == 8'h00, "R1 rdata", cfg_rdata, 0);
      check(sys_rst_pulse == 1'b0, "R1 pulse", sys_rst_pulse, 0);
   endtask

   task automatic t_fields();
      wr(8'hE5);
      check(cfg_rdata == 8'h05, "R2 reserved masked", cfg_rdata, 8'h05);
      wr(8'hFF);
      check(cfg_rdata == 8'h1F, "R2 all fields", cfg_rdata, 8'h1F);
      idle(5);
      check(cfg_rdata == 8'h0F, "R3 enable set", cfg_rdata, 8'h0F);
      wr(8'h0A);
      check(cfg_rdata == 8'h0A, "R3 select loaded", cfg_rdata, 8'h0A);
      wr(8'h02);
      check(cfg_rdata[3] == 1'b1, "R5 off without arm ignored", cfg_rdata[3], 1);
   endtask

   task automatic t_arm_window();
      wr(8'h18);
      wr(8'h08);   // bit 4 = 0 must not clear arm
      for (int i = 1; i < 5; i++) begin
         check(cfg_rdata[4] == (i < 4), "R4 arm window", cfg_rdata[4], (i < 4));
         @(negedge clk);
      end
      check(cfg_rdata[4] == 1'b0, "R4 arm cleared", cfg_rdata[4], 0);
   endtask

   task automatic t_disable();
      wr(8'h18); idle(3); wr(8'h00);   // lands on the 4th edge
      check(cfg_rdata[3] == 1'b0, "R5 off at window end", cfg_rdata[3], 0);
      wr(8'h08);
      wr(8'h18); idle(4); wr(8'h00);   // one edge late
      check(cfg_rdata[3] == 1'b1, "R5 late off ignored", cfg_rdata[3], 1);
      turn_off();
      check(cfg_rdata[3] == 1'b0, "R5 off inside window", cfg_rdata[3], 0);
   endtask

   task automatic t_period(input int sel);
      int idx;
      int per;
      per = 1 << (BASE_EXP + sel);
      wr(8'h08 | 8'(sel));
      run_to_pulse(per + 4, idx);
      check(idx == per, "R6 period", idx, per);
      idle(1);
      check(sys_rst_pulse == 1'b0, "R7 one cycle", sys_rst_pulse, 0);
      run_to_pulse(per + 4, idx);
      check(idx == per, "R7 next period", idx, per);
      turn_off();
   endtask

   task automatic t_kick_collision();
      int idx;
      wr(8'h08);
      run_to_pulse(3, idx);
      check(idx == 0, "R6 no early pulse", idx, 0);
      tick_en = 1'b1; wd_kick = 1'b1;
      @(negedge clk);
      tick_en = 1'b0; wd_kick = 1'b0;
      check(sys_rst_pulse == 1'b0, "R8 kick wins", sys_rst_pulse, 0);
      run_to_pulse(12, idx);
      check(idx == 4, "R8 fresh period", idx, 4);
      turn_off();
   endtask

   task automatic t_tick_hold();
      int idx;
      wr(8'h08);
      run_to_pulse(2, idx);
      idle(6);
      check(sys_rst_pulse == 1'b0, "R10 no pulse idle", sys_rst_pulse, 0);
      run_to_pulse(12, idx);
      check(idx == 2, "R10 count held", idx, 2);
      turn_off();
   endtask

   task automatic t_off_quiet();
      int idx;
      wr(8'h00);
      run_to_pulse(600, idx);
      check(idx == 0, "R9 disabled quiet", idx, 0);
      wr(8'h09);
      run_to_pulse(20, idx);
      check(idx == 8, "R9 full period after enable", idx, 8);
      turn_off();
   endtask

   initial begin
      idle(3);
      t_reset();
      rst_n = 1'b1;
      idle(1);
      t_fields();
      turn_off();
      t_arm_window();
      t_disable();
      t_period(0);
      t_period(3);
      t_period(7);
      t_kick_collision();
      t_tick_hold();
      t_off_quiet();
      idle(2);
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule